// File: doc/BRIEF.md
# Registered Add/Subtract/Shift Unit with Status Flags

This block is a single-stage arithmetic slice for signed or unsigned N-bit operands. Each accepted operation is an addition, a subtraction or an arithmetic right shift. Addition and subtraction share one carry-propagate adder. Subtraction feeds the adder the inverted second operand and a forced carry-in of one.

A per-operation control bit chooses how signed overflow is handled. The result either wraps modulo 2^N or clamps to the nearest signed limit. The outputs are the result and four status flags: negative, zero, carry-out and signed overflow. All of these are captured in a register one clock after a valid request.

Top module: `alu_slice`

## Requirements
- R1: With opcode 2'b00 (add), the result is (A + B) mod 2^N when saturation is off, and the carry flag is bit N of the unsigned sum.
- R2: With opcode 2'b01 (subtract), the result is (A + ~B + 1) mod 2^N when saturation is off. The carry flag is the carry-out of that sum, so it is 1 exactly when A >= B unsigned.
- R3: For add and subtract, the overflow flag is 1 exactly when the true signed result lies outside [-2^(N-1), 2^(N-1)-1].
- R4: With the saturate bit set, an overflowing add or subtract yields 2^(N-1)-1 when the true result is too large and -2^(N-1) when it is too small. The overflow flag is still 1 in that case.
- R5: With opcode 2'b10 or 2'b11 (shift), the result is A shifted right arithmetically by the shift amount. The vacated upper bits are filled with copies of A's MSB.
- R6: A shift amount greater than N-1 shifts by exactly N-1.
- R7: The negative flag equals the MSB of the delivered result.
- R8: The zero flag is 1 exactly when every bit of the delivered result is 0, judged after any clamping.
- R9: For shifts, the carry and overflow flags are 0, and the saturate bit has no effect.
- R10: Result and flags appear one clock after the request with out_valid high. A cycle without in_valid gives out_valid low on the next cycle and leaves result and flags unchanged.
- R11: After synchronous reset, out_valid, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | W | First operand / value to shift |
| op_b | input | W | Second operand |
| op_code | input | 2 | 00 add, 01 subtract, 1x arithmetic right shift |
| sat_en | input | 1 | Clamp on signed overflow instead of wrapping |
| shamt | input | $clog2(W)+1 | Shift distance |
| out_valid | output | 1 | Result and flags are fresh |
| res | output | W | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Adder carry-out |
| flag_v | output | 1 | Signed overflow |

## Verification
Overflow detection and saturation can both act in the same cycle. When they do, the clamped value, the overflow flag and the zero and negative flags must all agree.

The bench provokes this with directed edges of the signed range: maximum plus one, minimum minus one, minimum plus minimum, and maximum minus minimum. It also runs a seeded random stream that includes operands near the limits. Every response is compared against a bench model that works in exact integer arithmetic and only then clamps or wraps.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_ASR  = 2'b10,
        OP_ASRX = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } alu_flags_t;

    function automatic logic op_is_shift(input alu_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        cout  = wide[W];
        // same-sign inputs with a result of the other sign
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_asr.sv
module alu_asr #(
    parameter int W   = 8,
    parameter int SHW = $clog2(W) + 1
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   y
);
    localparam int KW    = (W > 1) ? $clog2(W) : 1;
    localparam int LIMIT = W - 1;

    logic [KW-1:0] k;
    logic [W-1:0]  stage [KW+1];

    always_comb begin
        if (amt > SHW'(LIMIT)) k = KW'(LIMIT);
        else                   k = amt[KW-1:0];
    end

    assign stage[0] = a;

    // logarithmic shifter, one conditional stage per bit of k
    for (genvar s = 0; s < KW; s++) begin : g_stage
        always_comb begin
            if (k[s]) stage[s+1] = W'($signed(stage[s]) >>> (1 << s));
            else      stage[s+1] = stage[s];
        end
    end

    assign y = stage[KW];
endmodule

// File: rtl/alu_clamp.sv
module alu_clamp #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic         ovf,
    input  logic         en,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (en && ovf) y = raw[W-1] ? POS_LIM : NEG_LIM;
        else           y = raw;
    end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
#(
    parameter int W   = 8,
    parameter int SHW = $clog2(W) + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic [1:0]     op_code,
    input  logic           sat_en,
    input  logic [SHW-1:0] shamt,
    output logic           out_valid,
    output logic [W-1:0]   res,
    output logic           flag_n,
    output logic           flag_z,
    output logic           flag_c,
    output logic           flag_v
);
    alu_op_e    op;
    logic [W-1:0] sum, shifted, clamped, nxt_res;
    logic       cout, ovf;
    alu_flags_t nxt_flags, flags_q;

    assign op = alu_op_e'(op_code);

    alu_addsub #(.W(W)) i_addsub (
        .a(op_a), .b(op_b), .sub(op == OP_SUB),
        .sum(sum), .cout(cout), .ovf(ovf)
    );

    alu_asr #(.W(W), .SHW(SHW)) i_asr (
        .a(op_a), .amt(shamt), .y(shifted)
    );

    alu_clamp #(.W(W)) i_clamp (
        .raw(sum), .ovf(ovf), .en(sat_en), .y(clamped)
    );

    always_comb begin
        if (op_is_shift(op)) begin
            nxt_res         = shifted;
            nxt_flags.carry = 1'b0;
            nxt_flags.ovf   = 1'b0;
        end else begin
            nxt_res         = clamped;
            nxt_flags.carry = cout;
            nxt_flags.ovf   = ovf;
        end
        nxt_flags.neg  = nxt_res[W-1];
        nxt_flags.zero = (nxt_res == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res       <= '0;
            flags_q   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res     <= nxt_res;
                flags_q <= nxt_flags;
            end
        end
    end

    assign flag_n = flags_q.neg;
    assign flag_z = flags_q.zero;
    assign flag_c = flags_q.carry;
    assign flag_v = flags_q.ovf;
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
    parameter int W   = 8,
    parameter int SHW = $clog2(W) + 1
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [1:0]     op_code,
    input logic           sat_en,
    input logic           out_valid,
    input logic [W-1:0]   res,
    input logic           flag_n,
    input logic           flag_z,
    input logic           flag_c,
    input logic           flag_v
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(res) && $stable(flag_v)));

    assert_neg_msb_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_n == res[W-1]));

    assert_zero_bits_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_z == (res == '0)));

    assert_shift_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[1]) |=> (!flag_c && !flag_v));

    assert_sat_limit_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat_en && !op_code[1]) |=>
            (!flag_v || res == POS_LIM || res == NEG_LIM));
endmodule

bind alu_slice alu_slice_chk #(.W(W), .SHW(SHW)) i_alu_slice_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .sat_en(sat_en), .out_valid(out_valid), .res(res),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/test_alu_slice.sv
`timescale 1ns/1ps
module test_alu_slice;
    localparam int W   = 8;
    localparam int SHW = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid;
    logic [W-1:0]   op_a, op_b;
    logic [1:0]     op_code;
    logic           sat_en;
    logic [SHW-1:0] shamt;
    logic           out_valid;
    logic [W-1:0]   res;
    logic           flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    alu_slice #(.W(W), .SHW(SHW)) i_alu_slice (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .op_code(op_code), .sat_en(sat_en), .shamt(shamt),
        .out_valid(out_valid), .res(res), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // exact-integer reference model
    task automatic model(input logic [7:0] a, input logic [7:0] b, input logic [1:0] op,
                         input logic sat, input logic [3:0] sh,
                         output logic [7:0] r, output logic c, output logic v);
        int sa, sb, exact, ua, ub, k;
        sa = $signed(a); sb = $signed(b); ua = a; ub = b;
        c = 1'b0; v = 1'b0;
        if (op[1]) begin
            k = (sh > 7) ? 7 : int'(sh);
            r = 8'(sa >>> k);
        end else begin
            if (op == 2'b00) begin
                exact = sa + sb;
                c = (ua + ub) > 255;
            end else begin
                exact = sa - sb;
                c = (ua >= ub);
            end
            v = (exact > 127) || (exact < -128);
            if (sat && v) r = (exact > 0) ? 8'h7f : 8'h80;
            else          r = 8'(exact);
        end
    endtask

    task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [1:0] op,
                          input logic sat, input logic [3:0] sh, input string req);
        logic [7:0] er;
        logic ec, ev;
        model(a, b, op, sat, sh, er, ec, ev);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; op_code = op; sat_en = sat; shamt = sh;
        @(posedge clk); #1;
        in_valid = 1'b0;
        check({req, " valid R10"}, 32'(out_valid), 32'd1);
        check({req, " result"}, 32'(res), 32'(er));
        check({req, " carry R2"}, 32'(flag_c), 32'(ec));
        check({req, " ovf R3"}, 32'(flag_v), 32'(ev));
        check({req, " neg R7"}, 32'(flag_n), 32'(er[7]));
        check({req, " zero R8"}, 32'(flag_z), 32'(er == 8'h00));
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; op_code = '0; sat_en = 1'b0; shamt = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset valid", 32'(out_valid), 32'd0);
        check("R11 reset res", 32'(res), 32'd0);
        check("R11 reset flags", 32'({flag_n, flag_z, flag_c, flag_v}), 32'd0);
        @(negedge clk); rst = 1'b0;

        run_op(8'd20, 8'd30, 2'b00, 1'b0, 4'd0, "R1 add");
        run_op(8'hff, 8'h01, 2'b00, 1'b0, 4'd0, "R1 add carry zero");
        run_op(8'd5, 8'd9, 2'b01, 1'b0, 4'd0, "R2 sub borrow");
        run_op(8'd9, 8'd9, 2'b01, 1'b0, 4'd0, "R2 sub equal");
        run_op(8'h7f, 8'h01, 2'b00, 1'b0, 4'd0, "R3 add wrap");
        run_op(8'h80, 8'h01, 2'b01, 1'b0, 4'd0, "R3 sub wrap");
        run_op(8'h7f, 8'h01, 2'b00, 1'b1, 4'd0, "R4 sat pos");
        run_op(8'h80, 8'h80, 2'b00, 1'b1, 4'd0, "R4 sat neg");
        run_op(8'h80, 8'h01, 2'b01, 1'b1, 4'd0, "R4 sat sub neg");
        run_op(8'h7f, 8'h80, 2'b01, 1'b1, 4'd0, "R4 sat sub pos");
        run_op(8'h80, 8'h80, 2'b00, 1'b0, 4'd0, "R8 wrap to zero");
        run_op(8'hb5, 8'h00, 2'b10, 1'b0, 4'd2, "R5 asr neg");
        run_op(8'h64, 8'h00, 2'b11, 1'b0, 4'd3, "R5 asr pos op11");
        run_op(8'h80, 8'h00, 2'b10, 1'b0, 4'd15, "R6 asr clamp");
        run_op(8'h40, 8'h00, 2'b10, 1'b0, 4'd8, "R6 asr clamp zero");
        run_op(8'h7f, 8'h7f, 2'b10, 1'b1, 4'd1, "R9 shift ignores sat");

        // R10: idle cycle keeps outputs and drops out_valid
        held = res;
        @(negedge clk); in_valid = 1'b0; op_a = 8'h11; op_code = 2'b00;
        @(posedge clk); #1;
        check("R10 idle valid", 32'(out_valid), 32'd0);
        check("R10 idle hold", 32'(res), 32'(held));

        for (int i = 0; i < 600; i++) begin
            logic [7:0] ra, rb;
            ra = 8'($urandom);
            rb = 8'($urandom);
            if (i % 5 == 0) ra = {ra[7], 7'h7e} | 8'($urandom % 2);
            run_op(ra, rb, 2'($urandom), 1'($urandom), 4'($urandom), "R1-random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule